// File: doc/BRIEF.md
# Descriptor activation status controller

This block is the launching side of a broadcast messaging unit. Software starts a broadcast with one write to an activation register. The write carries a push flag and a requester index. The block then offers that requester's descriptor to the network on a send stream. It tracks the replies that come back from every destination and keeps a two-bit status field for each requester. Software polls the field until it reads idle.

Two kinds of failure are reported as separate states, so that software can pick its recovery path:
- A source timeout means the network never took the descriptor.
- A destination timeout means the descriptor left, but not every destination answered in time.

A new push on a timed-out requester is the retry: it restarts the whole operation. Timeouts are measured in `tick` pulses against two programmable limits. The counter restarts on every push and again at launch.

The send port is valid/ready. Once `send_valid` is raised with an index, index and valid hold until `send_ready` is seen. The single exception: the offer is withdrawn if the offered requester reaches its source-timeout limit, which can only happen on a cycle with `tick` high. When several requesters are waiting and no offer is held, the lowest index is offered first.

Top module: `desc_act_ctrl`

## Requirements
- R1: After reset every status field reads 0 (idle), `send_valid` is 0 and `push_err` is 0.
- R2: An activation is `act_wr` high with `act_data[15]` set; the requester index is `act_data[3:0]`. An accepted push makes that field read 1 (active) on the next clock. A write with bit 15 clear, or with an index of 12 or more, changes no field and offers no send.
- R3: The field of requester i < 8 sits at `status0[2i+1:2i]`. The field of requester i >= 8 sits at `status1[2(i-8)+1:2(i-8)]`. The encoding is 0 idle, 1 active, 2 destination timeout, 3 source timeout. Unused `status1` bits read 0.
- R4: A pushed requester is offered on `send_valid`/`send_idx`. The offer holds, with a stable index, until `send_ready`. Among fresh offers the lowest index goes first. Each accepted push produces exactly one send.
- R5: If the send is not accepted by the `src_limit`-th `tick` after the push, the field becomes 3 and the offer is withdrawn.
- R6: After launch the field stays 1 until all 4 destinations have replied (`reply_valid` with `reply_req` equal to the requester and `reply_dest` naming the destination). It reads 0 on the clock after the last reply.
- R7: A launched requester still missing replies at the `dst_limit`-th tick reads 2. It keeps reading 2 while further ticks arrive, and goes to 0 once the late replies complete the set.
- R8: A push on a field reading 2 or 3 is accepted. The field reads 1, a fresh send is offered, the timeout count restarts, and all 4 destinations are pending again.
- R9: A push on a field reading 1 is ignored. `push_err` is high for exactly the one cycle after that write, and the state is unchanged.
- R10: A retry push and the final missing reply for the same destination-timed-out requester in one cycle: the push wins, and the field reads 1.
- R11: A send handshake and the source-timeout tick for the same requester in one cycle: the launch wins, and the field stays 1.
- R12: A reply for a requester that is not awaiting replies (idle, or still waiting to send) is ignored and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_wr | input | 1 | Activation register write strobe |
| act_data | input | 16 | Write data: push flag at bit 15, requester index at bits 3:0 |
| tick | input | 1 | Timeout time base pulse |
| src_limit | input | 8 | Ticks allowed before the send is accepted |
| dst_limit | input | 8 | Ticks allowed after launch for all replies |
| reply_valid | input | 1 | A destination reply is present |
| reply_req | input | 4 | Requester the reply belongs to |
| reply_dest | input | 2 | Destination that replied |
| send_valid | output | 1 | A descriptor launch is offered |
| send_ready | input | 1 | Network accepts the offered launch |
| send_idx | output | 4 | Requester index of the offered descriptor |
| status0 | output | 16 | Packed fields of requesters 0 to 7 |
| status1 | output | 16 | Packed fields of requesters 8 to 11, upper bits zero |
| push_err | output | 1 | One-cycle flag: a push hit an active requester |

## Verification
Two pairs of events can land on the same clock.

The first pair is a retry push and the last outstanding reply, both aimed at a requester in destination timeout. The bench drives both in the same cycle and expects the field to read active, not idle, on the next clock. A fresh send offer must also appear.

The second pair is a send handshake and the tick that would expire a requester's source limit. The bench holds `send_ready` and `tick` together after the limit minus one ticks. It expects the field to stay active with no offer left, and the requester must then complete normally on its replies.

// File: rtl/desc_act_ctrl_pkg.sv
package desc_act_ctrl_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_WAIT_SEND,
    RS_WAIT_REPLY,
    RS_DST_TO,
    RS_SRC_TO
  } req_state_e;

  localparam logic [1:0] FLD_IDLE   = 2'd0;
  localparam logic [1:0] FLD_ACTIVE = 2'd1;
  localparam logic [1:0] FLD_DST_TO = 2'd2;
  localparam logic [1:0] FLD_SRC_TO = 2'd3;

  function automatic logic [1:0] field_of(req_state_e s);
    case (s)
      RS_WAIT_SEND, RS_WAIT_REPLY: field_of = FLD_ACTIVE;
      RS_DST_TO:                   field_of = FLD_DST_TO;
      RS_SRC_TO:                   field_of = FLD_SRC_TO;
      default:                     field_of = FLD_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/desc_act_req_fsm.sv
module desc_act_req_fsm
  import desc_act_ctrl_pkg::*;
#(
  parameter int NUM_DEST = 4,
  parameter int CNT_W    = 8,
  localparam int DEST_W  = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              launch,
  input  logic              tick,
  input  logic [CNT_W-1:0]  src_limit,
  input  logic [CNT_W-1:0]  dst_limit,
  input  logic              reply_hit,
  input  logic [DEST_W-1:0] reply_dest,
  output logic [1:0]        field,
  output logic              want_send
);

  req_state_e          st, st_n;
  logic [CNT_W-1:0]    cnt, cnt_n;
  logic [NUM_DEST-1:0] pend, pend_n;
  logic [NUM_DEST-1:0] hit_mask, left;
  logic [CNT_W:0]      cnt_inc;
  logic                src_due, dst_due;

  assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign src_due = tick && (cnt_inc >= {1'b0, src_limit});
  assign dst_due = tick && (cnt_inc >= {1'b0, dst_limit});

  always_comb begin
    hit_mask = '0;
    if (reply_hit) hit_mask[reply_dest] = 1'b1;
    left = pend & ~hit_mask;
  end

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    pend_n = pend;
    case (st)
      RS_IDLE: begin
        if (push) begin
          st_n  = RS_WAIT_SEND;
          cnt_n = '0;
        end
      end
      RS_WAIT_SEND: begin
        if (launch) begin
          st_n   = RS_WAIT_REPLY;
          cnt_n  = '0;
          pend_n = '1;
        end else if (src_due) begin
          st_n  = RS_SRC_TO;
          cnt_n = '0;
        end else if (tick) begin
          cnt_n = cnt_inc[CNT_W-1:0];
        end
      end
      RS_WAIT_REPLY: begin
        pend_n = left;
        if (left == '0) begin
          st_n  = RS_IDLE;
          cnt_n = '0;
        end else if (dst_due) begin
          st_n  = RS_DST_TO;
          cnt_n = '0;
        end else if (tick) begin
          cnt_n = cnt_inc[CNT_W-1:0];
        end
      end
      RS_DST_TO: begin
        if (push) begin
          st_n  = RS_WAIT_SEND;
          cnt_n = '0;
        end else begin
          pend_n = left;
          if (left == '0) st_n = RS_IDLE;
        end
      end
      RS_SRC_TO: begin
        if (push) begin
          st_n  = RS_WAIT_SEND;
          cnt_n = '0;
        end
      end
      default: st_n = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= RS_IDLE;
      cnt  <= '0;
      pend <= '0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      pend <= pend_n;
    end
  end

  assign field     = field_of(st);
  assign want_send = (st == RS_WAIT_SEND);

endmodule

// File: rtl/desc_act_send_arb.sv
module desc_act_send_arb #(
  parameter int NUM_REQ = 12,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] want,
  input  logic               send_ready,
  output logic               send_valid,
  output logic [IDX_W-1:0]   send_idx,
  output logic [NUM_REQ-1:0] grant
);

  logic             lock_vld;
  logic [IDX_W-1:0] lock_idx;
  logic             lock_live, found;
  logic [IDX_W-1:0] pick;

  always_comb begin
    lock_live = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (lock_vld && (lock_idx == IDX_W'(i)) && want[i]) lock_live = 1'b1;
    end
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (want[i] && !found) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
  end

  assign send_valid = lock_live || found;
  assign send_idx   = lock_live ? lock_idx : pick;

  always_comb begin
    grant = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      grant[i] = send_valid && send_ready && (send_idx == IDX_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_vld <= 1'b0;
      lock_idx <= '0;
    end else begin
      lock_vld <= send_valid && !send_ready;
      lock_idx <= send_idx;
    end
  end

endmodule

// File: rtl/desc_act_status_pack.sv
module desc_act_status_pack #(
  parameter int NUM_REQ = 12,
  parameter int SPLIT   = 8,
  localparam int STAT_W = 2 * SPLIT
) (
  input  logic [2*NUM_REQ-1:0] fields,
  output logic [STAT_W-1:0]    status0,
  output logic [STAT_W-1:0]    status1
);

  for (genvar i = 0; i < SPLIT; i++) begin : g_lo
    if (i < NUM_REQ) begin : g_used
      assign status0[2*i +: 2] = fields[2*i +: 2];
    end else begin : g_empty
      assign status0[2*i +: 2] = 2'b00;
    end
  end

  for (genvar j = 0; j < SPLIT; j++) begin : g_hi
    if (j + SPLIT < NUM_REQ) begin : g_used
      assign status1[2*j +: 2] = fields[2*(j+SPLIT) +: 2];
    end else begin : g_empty
      assign status1[2*j +: 2] = 2'b00;
    end
  end

endmodule

// File: rtl/desc_act_ctrl.sv
module desc_act_ctrl
  import desc_act_ctrl_pkg::*;
#(
  parameter int NUM_REQ  = 12,
  parameter int SPLIT    = 8,
  parameter int NUM_DEST = 4,
  parameter int IDX_W    = 4,
  parameter int ACT_W    = 16,
  parameter int PUSH_POS = 15,
  parameter int CNT_W    = 8,
  localparam int DEST_W  = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
  localparam int STAT_W  = 2 * SPLIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_wr,
  input  logic [ACT_W-1:0]  act_data,
  input  logic              tick,
  input  logic [CNT_W-1:0]  src_limit,
  input  logic [CNT_W-1:0]  dst_limit,
  input  logic              reply_valid,
  input  logic [IDX_W-1:0]  reply_req,
  input  logic [DEST_W-1:0] reply_dest,
  output logic              send_valid,
  input  logic              send_ready,
  output logic [IDX_W-1:0]  send_idx,
  output logic [STAT_W-1:0] status0,
  output logic [STAT_W-1:0] status1,
  output logic              push_err
);

  localparam logic [IDX_W:0] REQ_LIM = (IDX_W+1)'(NUM_REQ);

  logic               push_flag, idx_ok, hit_busy;
  logic [IDX_W-1:0]   req_idx;
  logic [NUM_REQ-1:0] push_vec, want, grant, reply_vec, busy;
  logic [2*NUM_REQ-1:0] fields;
  logic               unused_act;

  assign push_flag  = act_data[PUSH_POS];
  assign req_idx    = act_data[IDX_W-1:0];
  assign idx_ok     = ({1'b0, req_idx} < REQ_LIM);
  assign unused_act = ^act_data[PUSH_POS-1:IDX_W];

  always_comb begin
    hit_busy = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      push_vec[i]  = act_wr && push_flag && idx_ok && (req_idx == IDX_W'(i));
      reply_vec[i] = reply_valid && (reply_req == IDX_W'(i));
      busy[i]      = (fields[2*i +: 2] == FLD_ACTIVE);
      if (push_vec[i] && busy[i]) hit_busy = 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    desc_act_req_fsm #(
      .NUM_DEST (NUM_DEST),
      .CNT_W    (CNT_W)
    ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push_vec[g]),
      .launch     (grant[g]),
      .tick       (tick),
      .src_limit  (src_limit),
      .dst_limit  (dst_limit),
      .reply_hit  (reply_vec[g]),
      .reply_dest (reply_dest),
      .field      (fields[2*g +: 2]),
      .want_send  (want[g])
    );
  end

  desc_act_send_arb #(
    .NUM_REQ (NUM_REQ),
    .IDX_W   (IDX_W)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .want       (want),
    .send_ready (send_ready),
    .send_valid (send_valid),
    .send_idx   (send_idx),
    .grant      (grant)
  );

  desc_act_status_pack #(
    .NUM_REQ (NUM_REQ),
    .SPLIT   (SPLIT)
  ) u_pack (
    .fields  (fields),
    .status0 (status0),
    .status1 (status1)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) push_err <= 1'b0;
    else        push_err <= hit_busy;
  end

endmodule

// File: rtl/desc_act_ctrl_chk.sv
module desc_act_ctrl_chk #(
  parameter int NUM_REQ  = 12,
  parameter int SPLIT    = 8,
  parameter int IDX_W    = 4,
  parameter int ACT_W    = 16,
  parameter int PUSH_POS = 15,
  localparam int STAT_W  = 2 * SPLIT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              act_wr,
  input logic [ACT_W-1:0]  act_data,
  input logic              tick,
  input logic              send_valid,
  input logic              send_ready,
  input logic [IDX_W-1:0]  send_idx,
  input logic [STAT_W-1:0] status0,
  input logic [STAT_W-1:0] status1,
  input logic              push_err
);

  function automatic logic [STAT_W-1:0] used_hi_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int j = 0; j < SPLIT; j++) begin
      if (j + SPLIT < NUM_REQ) m[2*j +: 2] = 2'b11;
    end
    return m;
  endfunction

  localparam logic [STAT_W-1:0] HI_MASK = used_hi_mask();

  logic [2*STAT_W-1:0] all_f;
  logic [IDX_W-1:0]    widx;
  logic                push_ok;
  logic [1:0]          wfld, sfld;

  assign all_f   = {status1, status0};
  assign widx    = act_data[IDX_W-1:0];
  assign push_ok = act_wr && act_data[PUSH_POS] && ({1'b0, widx} < (IDX_W+1)'(NUM_REQ));
  assign wfld    = all_f[2*widx +: 2];
  assign sfld    = all_f[2*send_idx +: 2];

  // R2
  push_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && (wfld != 2'd1) |=> (all_f[2*$past(widx) +: 2] == 2'd1));

  // R9
  push_busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && (wfld == 2'd1) |=> push_err);

  // R9
  push_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_err |-> $past(push_ok));

  // R4
  send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_valid && !send_ready && !tick |=> send_valid && $stable(send_idx));

  // R4
  send_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_valid |-> (sfld == 2'd1));

  // R3
  hi_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status1 & ~HI_MASK) == '0);

endmodule

bind desc_act_ctrl desc_act_ctrl_chk #(
  .NUM_REQ  (NUM_REQ),
  .SPLIT    (SPLIT),
  .IDX_W    (IDX_W),
  .ACT_W    (ACT_W),
  .PUSH_POS (PUSH_POS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .act_wr     (act_wr),
  .act_data   (act_data),
  .tick       (tick),
  .send_valid (send_valid),
  .send_ready (send_ready),
  .send_idx   (send_idx),
  .status0    (status0),
  .status1    (status1),
  .push_err   (push_err)
);

// File: tb/desc_act_ctrl_test.sv
module desc_act_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_wr = 1'b0;
  logic [15:0] act_data = '0;
  logic        tick = 1'b0;
  logic [7:0]  src_limit = 8'd5;
  logic [7:0]  dst_limit = 8'd5;
  logic        reply_valid = 1'b0;
  logic [3:0]  reply_req = '0;
  logic [1:0]  reply_dest = '0;
  logic        send_valid;
  logic        send_ready = 1'b0;
  logic [3:0]  send_idx;
  logic [15:0] status0, status1;
  logic        push_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  desc_act_ctrl uut (
    .clk(clk), .rst_n(rst_n), .act_wr(act_wr), .act_data(act_data),
    .tick(tick), .src_limit(src_limit), .dst_limit(dst_limit),
    .reply_valid(reply_valid), .reply_req(reply_req), .reply_dest(reply_dest),
    .send_valid(send_valid), .send_ready(send_ready), .send_idx(send_idx),
    .status0(status0), .status1(status1), .push_err(push_err)
  );

  function automatic int fld(int i);
    logic [31:0] a;
    a = {status1, status0};
    return int'(a[2*i +: 2]);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_raw(logic [15:0] d);
    act_wr = 1'b1; act_data = d;
    @(negedge clk);
    act_wr = 1'b0; act_data = '0;
  endtask

  task automatic push(int idx);
    write_raw(16'h8000 | 16'(idx));
  endtask

  task automatic handshake();
    send_ready = 1'b1;
    @(negedge clk);
    send_ready = 1'b0;
  endtask

  task automatic reply(int r, int d);
    reply_valid = 1'b1; reply_req = 4'(r); reply_dest = 2'(d);
    @(negedge clk);
    reply_valid = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic all_replies(int r);
    for (int d = 0; d < 4; d++) reply(r, d);
  endtask

  task automatic t_reset();
    check("R1", "status0", int'(status0), 0);
    check("R1", "status1", int'(status1), 0);
    check("R1", "send_valid", int'(send_valid), 0);
    check("R1", "push_err", int'(push_err), 0);
  endtask

  task automatic t_basic();
    write_raw(16'h0002);
    check("R2", "no push flag field2", fld(2), 0);
    check("R2", "no push flag send", int'(send_valid), 0);
    write_raw(16'h800D);
    check("R2", "bad index fields", int'({status1, status0}), 0);
    check("R2", "bad index send", int'(send_valid), 0);
    push(2);
    check("R2", "field2 active", fld(2), 1);
    check("R3", "status0[5:4]", int'(status0[5:4]), 1);
    check("R9", "no err on idle push", int'(push_err), 0);
    check("R4", "offer valid", int'(send_valid), 1);
    check("R4", "offer idx", int'(send_idx), 2);
    reply(2, 0);  // R12 stray reply before launch
    push(9);
    check("R3", "status1[3:2]", int'(status1[3:2]), 1);
    check("R4", "held idx", int'(send_idx), 2);
    handshake();
    check("R4", "next offer idx", int'(send_idx), 9);
    check("R4", "next offer valid", int'(send_valid), 1);
    handshake();
    check("R4", "no more offers", int'(send_valid), 0);
    reply(2, 1); reply(2, 2); reply(2, 3);
    check("R12", "stray reply not counted", fld(2), 1);
    reply(2, 0);
    check("R6", "field2 complete", fld(2), 0);
    reply(9, 3); reply(9, 1); reply(9, 0);
    check("R6", "field9 partial", fld(9), 1);
    reply(9, 2);
    check("R6", "field9 complete", fld(9), 0);
  endtask

  task automatic t_busy_push();
    push(4);
    push(4);
    check("R9", "err pulse", int'(push_err), 1);
    check("R9", "field4 kept", fld(4), 1);
    @(negedge clk);
    check("R9", "err one cycle", int'(push_err), 0);
    handshake();
    check("R4", "single send", int'(send_valid), 0);
    all_replies(4);
    check("R6", "field4 idle", fld(4), 0);
  endtask

  task automatic t_src_timeout();
    push(5);
    ticks(4);
    check("R5", "before limit", fld(5), 1);
    ticks(1);
    check("R5", "source timeout", fld(5), 3);
    check("R5", "offer withdrawn", int'(send_valid), 0);
    push(5);
    check("R8", "retry active", fld(5), 1);
    check("R8", "retry offer idx", int'(send_idx), 5);
    ticks(4);
    check("R8", "count restarted", fld(5), 1);
    handshake();
    all_replies(5);
    check("R6", "field5 idle", fld(5), 0);
  endtask

  task automatic t_dst_timeout();
    push(6);
    handshake();
    reply(6, 0); reply(6, 1); reply(6, 2);
    ticks(4);
    check("R7", "before limit", fld(6), 1);
    ticks(1);
    check("R7", "destination timeout", fld(6), 2);
    ticks(3);
    check("R7", "stays readable", fld(6), 2);
    reply(6, 3);
    check("R7", "late completion", fld(6), 0);
    push(6);
    handshake();
    ticks(5);
    check("R7", "second timeout", fld(6), 2);
    push(6);
    check("R8", "retry from dst timeout", fld(6), 1);
    check("R8", "retry offer idx", int'(send_idx), 6);
    handshake();
    reply(6, 0); reply(6, 1); reply(6, 2);
    check("R8", "all dests pending again", fld(6), 1);
    reply(6, 3);
    check("R6", "field6 idle", fld(6), 0);
  endtask

  task automatic t_push_vs_reply();
    push(7);
    handshake();
    reply(7, 0); reply(7, 1); reply(7, 2);
    ticks(5);
    check("R7", "field7 timed out", fld(7), 2);
    act_wr = 1'b1; act_data = 16'h8007;
    reply_valid = 1'b1; reply_req = 4'd7; reply_dest = 2'd3;
    @(negedge clk);
    act_wr = 1'b0; act_data = '0; reply_valid = 1'b0;
    check("R10", "push beats last reply", fld(7), 1);
    check("R10", "fresh offer", int'(send_idx), 7);
    handshake();
    all_replies(7);
    check("R10", "field7 idle", fld(7), 0);
  endtask

  task automatic t_launch_vs_timeout();
    push(8);
    check("R3", "status1[1:0]", int'(status1[1:0]), 1);
    ticks(4);
    tick = 1'b1; send_ready = 1'b1;
    @(negedge clk);
    tick = 1'b0; send_ready = 1'b0;
    check("R11", "launch beats timeout", fld(8), 1);
    check("R11", "offer consumed", int'(send_valid), 0);
    all_replies(8);
    check("R11", "field8 idle", fld(8), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_busy_push();
    t_src_timeout();
    t_dst_timeout();
    t_push_vs_reply();
    t_launch_vs_timeout();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

endmodule